// File: doc/BRIEF.md
# Link Init Handshake and SPI Ownership Controller

This block arbitrates one shared SPI master between an embedded configuration agent and the host. After power-up the agent runs a one-time link configuration, modelled here as a fixed count of clock cycles. Only when that work completes does the host gain the SPI master. The host sees the handshake through four 32-bit registers on an internal register bus: an init register, a read-only firmware version word, and one mode status word per link group.

The firmware version decides how the run is triggered. Agents with major version 3 or later wait for the host to write a start request. That request carries a 2-bit FEC mode for every link. Older agents start on their own when reset is released. When no agent is built in, the version reads zero and the host owns the SPI master from the first clock after reset. A status value of 0x100 or more marks an initialization error. Such an error does not stop the done flag from setting, and it does not stop ownership from passing.

Top module: `link_init_handshake`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `spi_host_own` and `spi_req_out` are 0 and `bus_rvalid` is 0. An agent-built instance then reads 0 from its init register.
- R2: The version register at address 0x1004 reads the major field in bits 31:28, the minor field in bits 27:24, the patch field in bits 23:20, and 0 in bits 19:0.
- R3: The init register is at address 0x1000, with bit 0 as done and bit 1 as start. A write with bit 1 set is accepted when the agent is at major version 3 or later and neither start nor done is set. An accepted write sets start and stores bits 23:8 as eight 2-bit FEC fields: group A links 0..3 in bits 9:8 to 15:14, then group B links 0..3 in bits 17:16 to 23:22, with encoding 0 = none, 1 = KR, 2 = RS. The fields read back exactly as written.
- R4: An init register write with bit 1 clear changes nothing and does not start configuration.
- R5: Done and `spi_host_own` both rise exactly CFG_CYCLES clock edges after the edge that accepts a start write.
- R6: Once start or done is set, further init register writes leave every init bit unchanged.
- R7: Done and `spi_host_own` stay set until reset.
- R8: The group status registers are at 0x1020 (group A, `grp_status_in` bits 31:0) and 0x1024 (group B, bits 63:32). They read 0 before done. At done they capture the inputs, and ownership still passes when a value is 0x100 or more.
- R9: `spi_req_out` equals `host_spi_req` while the host owns the SPI master, and is 0 otherwise.
- R10: An agent with major version below 3 starts without a host request. Its done bit and ownership rise CFG_CYCLES edges after reset release, and its start bit and FEC fields stay 0.
- R11: Without an agent, version and init read 0, init writes are ignored, and `spi_host_own` is 1 from the first edge after reset release.
- R12: A read returns its data on the cycle after the request, with `bus_rvalid` high. Unmapped addresses read 0, and writes to read-only registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register bus request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| grp_status_in | input | NUM_GROUPS*32 | Per-group mode status reported by the agent |
| host_spi_req | input | 1 | Host request toward the SPI master |
| spi_req_out | output | 1 | Gated SPI request |
| spi_host_own | output | 1 | SPI master owned by the host |

## Verification
The bench sweeps uniform none, KR and RS modes and a mixed per-link pattern. A field mapping that is shifted or swapped by group would fail the readback. A start write without the start bit must leave the block idle; a design that triggered on any init write would hand over the SPI master early. Ownership is sampled one edge before and at the expected handover, which catches off-by-one timers. Status values at and above 0x100 check that an error does not hold back handover. A second start after done, a write to the version word and reads of unmapped addresses check that nothing leaks through. Three variants run side by side: host-started, self-starting legacy and no agent.

// File: rtl/ihs_pkg.sv
package ihs_pkg;
   localparam int DATA_W        = 32;
   localparam int ADR_INIT      = 'h1000;
   localparam int ADR_VERSION   = 'h1004;
   localparam int ADR_STAT_BASE = 'h1020;
   localparam int STAT_STRIDE   = 4;
   localparam int DONE_BIT      = 0;
   localparam int START_BIT     = 1;
   localparam int FEC_LSB       = 8;
   localparam int VER_FIELD_W   = 4;
   localparam int VER_PATCH_LSB = 20;
   localparam int VER_MINOR_LSB = 24;
   localparam int VER_MAJOR_LSB = 28;
   localparam int HOST_START_MIN_MAJOR = 3;

   typedef enum logic [1:0] {
      SEQ_WAIT = 2'd0,
      SEQ_RUN  = 2'd1,
      SEQ_DONE = 2'd2
   } seq_state_e;
endpackage

// File: rtl/ihs_cfg_seq.sv
module ihs_cfg_seq
   import ihs_pkg::*;
#(
   parameter int CFG_CYCLES = 64,
   parameter bit AUTO_START = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   output logic cfg_finish,
   output logic cfg_done
);
   localparam int CNT_W = (CFG_CYCLES > 1) ? $clog2(CFG_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CFG_CYCLES - 1);

   seq_state_e state_q;
   logic [CNT_W-1:0] cnt_q;

   assign cfg_finish = (state_q == SEQ_RUN) && (cnt_q == CNT_LAST);
   assign cfg_done   = (state_q == SEQ_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= AUTO_START ? SEQ_RUN : SEQ_WAIT;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            SEQ_WAIT: if (start_req) begin
               state_q <= SEQ_RUN;
               cnt_q   <= '0;
            end
            SEQ_RUN: begin
               if (cnt_q == CNT_LAST) state_q <= SEQ_DONE;
               else                   cnt_q   <= cnt_q + 1'b1;
            end
            default: state_q <= SEQ_DONE;
         endcase
      end
   end

   AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_done) |-> $past(state_q == SEQ_RUN)); // R5
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> cfg_done); // R7
   AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_RUN) |-> (cnt_q <= CNT_LAST)); // R5
endmodule

// File: rtl/ihs_regfile.sv
module ihs_regfile
   import ihs_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int NUM_GROUPS      = 2,
   parameter int LINKS_PER_GROUP = 4,
   parameter int FEC_W           = 2,
   parameter bit AGENT_PRESENT   = 1'b1,
   parameter bit HOST_START      = 1'b1,
   parameter logic [VER_FIELD_W-1:0] VER_MAJOR = 4'd3,
   parameter logic [VER_FIELD_W-1:0] VER_MINOR = 4'd0,
   parameter logic [VER_FIELD_W-1:0] VER_PATCH = 4'd1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_req,
   input  logic                         bus_we,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   input  logic [NUM_GROUPS*DATA_W-1:0] grp_status_in,
   input  logic                         cfg_done,
   input  logic                         cfg_finish,
   output logic                         start_pulse,
   output logic [DATA_W-1:0]            bus_rdata,
   output logic                         bus_rvalid
);
   localparam int FEC_BITS = NUM_GROUPS * LINKS_PER_GROUP * FEC_W;
   localparam logic [DATA_W-1:0] VER_WORD = AGENT_PRESENT ?
      ((DATA_W'(VER_MAJOR) << VER_MAJOR_LSB) |
       (DATA_W'(VER_MINOR) << VER_MINOR_LSB) |
       (DATA_W'(VER_PATCH) << VER_PATCH_LSB)) : '0;

   logic                         start_q;
   logic [FEC_BITS-1:0]          fec_q;
   logic [NUM_GROUPS*DATA_W-1:0] stat_q;
   logic [DATA_W-1:0]            rd_mux;
   logic [DATA_W-1:0]            rdata_q;
   logic                         rvalid_q;
   logic                         hit_init;
   logic                         unused_wbits;

   assign unused_wbits = ^bus_wdata;
   assign hit_init     = (bus_addr == ADDR_W'(ADR_INIT));
   assign start_pulse  = HOST_START && bus_req && bus_we && hit_init &&
                         bus_wdata[START_BIT] && !start_q && !cfg_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         fec_q   <= '0;
      end else if (start_pulse) begin
         start_q <= 1'b1;
         fec_q   <= bus_wdata[FEC_LSB +: FEC_BITS];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat_q <= '0;
      else if (cfg_finish) stat_q <= grp_status_in;
   end

   always_comb begin
      rd_mux = '0;
      if (hit_init) begin
         rd_mux[DONE_BIT]             = cfg_done;
         rd_mux[START_BIT]            = start_q;
         rd_mux[FEC_LSB +: FEC_BITS]  = fec_q;
      end else if (bus_addr == ADDR_W'(ADR_VERSION)) begin
         rd_mux = VER_WORD;
      end else begin
         for (int g = 0; g < NUM_GROUPS; g++) begin
            if (bus_addr == ADDR_W'(ADR_STAT_BASE + STAT_STRIDE * g))
               rd_mux = stat_q[g*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= bus_req && !bus_we;
         if (bus_req && !bus_we) rdata_q <= rd_mux;
      end
   end

   assign bus_rdata  = rdata_q;
   assign bus_rvalid = rvalid_q;

   AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> start_q); // R6
   AST_FEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start_q || cfg_done) |=> $stable(fec_q)); // R6
   AST_STAT_ZERO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_done |-> (stat_q == '0)); // R8
   AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_req && !bus_we)); // R12
endmodule

// File: rtl/ihs_spi_gate.sv
module ihs_spi_gate #(
   parameter bit ALWAYS_HOST = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_done,
   input  logic cfg_finish,
   input  logic host_spi_req,
   output logic spi_host_own,
   output logic spi_req_out
);
   logic own_q;

   generate
      if (ALWAYS_HOST) begin : g_free
         logic unused_seq;
         assign unused_seq = cfg_done ^ cfg_finish;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) own_q <= 1'b0;
            else        own_q <= 1'b1;
         end
      end else begin : g_handoff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          own_q <= 1'b0;
            else if (cfg_finish) own_q <= 1'b1;
         end
         AST_OWN_MATCHES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            spi_host_own == cfg_done); // R5
      end
   endgenerate

   assign spi_host_own = own_q;
   assign spi_req_out  = host_spi_req && own_q;

   AST_OWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      spi_host_own |=> spi_host_own); // R7
   AST_SPI_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_host_own |-> !spi_req_out); // R9
endmodule

// File: rtl/link_init_handshake.sv
module link_init_handshake
   import ihs_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int NUM_GROUPS      = 2,
   parameter int LINKS_PER_GROUP = 4,
   parameter int FEC_W           = 2,
   parameter int CFG_CYCLES      = 64,
   parameter bit AGENT_PRESENT   = 1'b1,
   parameter logic [3:0] VER_MAJOR = 4'd3,
   parameter logic [3:0] VER_MINOR = 4'd0,
   parameter logic [3:0] VER_PATCH = 4'd1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_req,
   input  logic                         bus_we,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [31:0]                  bus_wdata,
   output logic [31:0]                  bus_rdata,
   output logic                         bus_rvalid,
   input  logic [NUM_GROUPS*32-1:0]     grp_status_in,
   input  logic                         host_spi_req,
   output logic                         spi_req_out,
   output logic                         spi_host_own
);
   localparam int FEC_BITS   = NUM_GROUPS * LINKS_PER_GROUP * FEC_W;
   localparam bit HOST_START = AGENT_PRESENT && (int'(VER_MAJOR) >= HOST_START_MIN_MAJOR);
   localparam bit AUTO_START = AGENT_PRESENT && !HOST_START;

   generate
      if (FEC_LSB + FEC_BITS > DATA_W) begin : g_bad_fec
         $error("FEC fields do not fit in the init register");
      end
      if (CFG_CYCLES < 1) begin : g_bad_cfg
         $error("CFG_CYCLES must be at least 1");
      end
      if (ADDR_W < 13) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic start_pulse;
   logic cfg_finish;
   logic cfg_done;

   generate
      if (AGENT_PRESENT) begin : g_agent
         ihs_cfg_seq #(
            .CFG_CYCLES (CFG_CYCLES),
            .AUTO_START (AUTO_START)
         ) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_req  (start_pulse),
            .cfg_finish (cfg_finish),
            .cfg_done   (cfg_done)
         );
      end else begin : g_no_agent
         logic unused_start;
         assign unused_start = start_pulse;
         assign cfg_finish   = 1'b0;
         assign cfg_done     = 1'b0;
      end
   endgenerate

   ihs_regfile #(
      .ADDR_W          (ADDR_W),
      .NUM_GROUPS      (NUM_GROUPS),
      .LINKS_PER_GROUP (LINKS_PER_GROUP),
      .FEC_W           (FEC_W),
      .AGENT_PRESENT   (AGENT_PRESENT),
      .HOST_START      (HOST_START),
      .VER_MAJOR       (VER_MAJOR),
      .VER_MINOR       (VER_MINOR),
      .VER_PATCH       (VER_PATCH)
   ) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_req       (bus_req),
      .bus_we        (bus_we),
      .bus_addr      (bus_addr),
      .bus_wdata     (bus_wdata),
      .grp_status_in (grp_status_in),
      .cfg_done      (cfg_done),
      .cfg_finish    (cfg_finish),
      .start_pulse   (start_pulse),
      .bus_rdata     (bus_rdata),
      .bus_rvalid    (bus_rvalid)
   );

   ihs_spi_gate #(
      .ALWAYS_HOST (!AGENT_PRESENT)
   ) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_done     (cfg_done),
      .cfg_finish   (cfg_finish),
      .host_spi_req (host_spi_req),
      .spi_host_own (spi_host_own),
      .spi_req_out  (spi_req_out)
   );
endmodule

// File: tb/link_init_handshake_tb.sv
module link_init_handshake_tb;
   localparam int CLK_PERIOD = 10;
   localparam int TB_CFG     = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] stat_a = '0;
   logic [31:0] stat_b = '0;
   logic        host_spi_req = 1'b1;

   logic [31:0] rd_m, rd_l, rd_n;
   logic        rv_m, rv_l, rv_n;
   logic        own_m, own_l, own_n;
   logic        sro_m, sro_l, sro_n;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   link_init_handshake #(.CFG_CYCLES(TB_CFG), .AGENT_PRESENT(1'b1),
      .VER_MAJOR(4'd3), .VER_MINOR(4'd2), .VER_PATCH(4'd5)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_m),
      .bus_rvalid(rv_m), .grp_status_in({stat_b, stat_a}),
      .host_spi_req(host_spi_req), .spi_req_out(sro_m), .spi_host_own(own_m));

   link_init_handshake #(.CFG_CYCLES(TB_CFG), .AGENT_PRESENT(1'b1),
      .VER_MAJOR(4'd2), .VER_MINOR(4'd7), .VER_PATCH(4'd1)) u_legacy (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_l),
      .bus_rvalid(rv_l), .grp_status_in({stat_b, stat_a}),
      .host_spi_req(host_spi_req), .spi_req_out(sro_l), .spi_host_own(own_l));

   link_init_handshake #(.CFG_CYCLES(TB_CFG), .AGENT_PRESENT(1'b0),
      .VER_MAJOR(4'd3), .VER_MINOR(4'd1), .VER_PATCH(4'd1)) u_noagent (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_n),
      .bus_rvalid(rv_n), .grp_status_in({stat_b, stat_a}),
      .host_spi_req(host_spi_req), .spi_req_out(sro_n), .spi_host_own(own_n));

   task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
   endtask

   function automatic logic [15:0] fec_uniform(input int m);
      logic [15:0] v = '0;
      for (int i = 0; i < 8; i++) v[2*i +: 2] = 2'(m);
      return v;
   endfunction

   function automatic logic [15:0] fec_mixed();
      logic [15:0] v = '0;
      for (int i = 0; i < 8; i++) v[2*i +: 2] = 2'(i % 3);
      return v;
   endfunction

   task automatic host_trial(input int t, input logic [15:0] fec);
      stat_a = 32'(t) * 32'h80;
      stat_b = 32'h40 + 32'(t);
      do_reset();
      check_eq("R1 own after reset", {31'b0, own_m}, 32'h0);
      check_eq("R9 spi blocked after reset", {31'b0, sro_m}, 32'h0);
      check_eq("R1 rvalid after reset", {31'b0, rv_m}, 32'h0);
      bus_read(16'h1000);
      check_eq("R1 init reads zero", rd_m, 32'h0);
      check_eq("R12 rvalid on read", {31'b0, rv_m}, 32'h1);
      bus_read(16'h1020);
      check_eq("R8 status zero before done", rd_m, 32'h0);
      bus_write(16'h1000, {8'h00, ~fec, 8'h00});
      bus_read(16'h1000);
      check_eq("R4 write without start ignored", rd_m, 32'h0);
      bus_write(16'h1000, {8'h00, fec, 8'h02});
      repeat (TB_CFG - 1) @(negedge clk);
      check_eq("R5 own one edge early", {31'b0, own_m}, 32'h0);
      check_eq("R9 spi blocked before done", {31'b0, sro_m}, 32'h0);
      @(negedge clk);
      check_eq("R5 own at handover", {31'b0, own_m}, 32'h1);
      check_eq("R9 spi passes when owned", {31'b0, sro_m}, 32'h1);
      bus_read(16'h1000);
      check_eq("R3 init readback with done", rd_m, {8'h00, fec, 8'h03});
      bus_read(16'h1020);
      check_eq("R8 group A status", rd_m, stat_a);
      bus_read(16'h1024);
      check_eq("R8 group B status", rd_m, stat_b);
      bus_write(16'h1000, {8'h00, ~fec, 8'h02});
      bus_read(16'h1000);
      check_eq("R6 second start ignored", rd_m, {8'h00, fec, 8'h03});
      bus_write(16'h1004, 32'hFFFF_FFFF);
      bus_read(16'h1004);
      check_eq("R2 version fields", rd_m, 32'h3250_0000);
      bus_read(16'h1008);
      check_eq("R12 unmapped reads zero", rd_m, 32'h0);
      host_spi_req = 1'b0;
      repeat (10) @(negedge clk);
      check_eq("R7 own held", {31'b0, own_m}, 32'h1);
      check_eq("R9 spi follows host request", {31'b0, sro_m}, 32'h0);
      host_spi_req = 1'b1;
   endtask

   initial begin
      // variant phase: legacy self-start and absent agent
      stat_a = 32'h0000_0123;
      stat_b = 32'h0000_0011;
      do_reset();
      check_eq("R1 legacy own at reset", {31'b0, own_l}, 32'h0);
      check_eq("R1 no-agent own at reset", {31'b0, own_n}, 32'h0);
      check_eq("R1 no-agent spi at reset", {31'b0, sro_n}, 32'h0);
      @(negedge clk);
      check_eq("R11 no-agent own after first edge", {31'b0, own_n}, 32'h1);
      check_eq("R11 no-agent spi passes", {31'b0, sro_n}, 32'h1);
      repeat (TB_CFG - 2) @(negedge clk);
      check_eq("R10 legacy own one edge early", {31'b0, own_l}, 32'h0);
      @(negedge clk);
      check_eq("R10 legacy own at handover", {31'b0, own_l}, 32'h1);
      bus_write(16'h1000, 32'h00AA_AA02);
      bus_read(16'h1000);
      check_eq("R10 legacy init done only", rd_l, 32'h1);
      check_eq("R11 no-agent init zero", rd_n, 32'h0);
      bus_read(16'h1004);
      check_eq("R2 legacy version", rd_l, 32'h2710_0000);
      check_eq("R11 no-agent version zero", rd_n, 32'h0);
      bus_read(16'h1020);
      check_eq("R8 legacy error status still hands over", rd_l, 32'h0000_0123);

      for (int t = 0; t < 3; t++) host_trial(t, fec_uniform(t));
      host_trial(3, fec_mixed());
      host_trial(4, 16'h1B6C);

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule